// File: doc/BRIEF.md
# Dual-Half Latched Bus Transceiver

This block couples an A bus and a B bus through storage in both directions. The buses are split into independent halves (two halves of eight bits by default). Each half has one path that carries A toward B and one that carries B toward A. Every path has three active-low controls of its own: a path enable, a latch enable and an output enable. Each direction also has one active-low master clear. The clear for A-to-B acts on the A-to-B storage of every half at the same time, and the clear for B-to-A does the same for the other direction.

Each pad is modelled as a separate input, output and per-bit output-enable vector, so the block stays synthesizable. When a path's enable and latch enable are both low, the path is open and its destination follows its source with no register in between. While it is open, a register samples the source on every clock. When the path stops being open, the last sample is kept. This happens when the latch enable rises, and also when the enable rises. The destination is driven only when the path enable and output enable are both low.

Each path keeps a small state machine. PS_CLEAR is entered asynchronously whenever the path's master clear is low. Any state moves to PS_OPEN on a clock where the path is open. PS_OPEN moves to PS_HOLD on the first clock where the path is no longer open; this is the capture event. PS_CLEAR and PS_HOLD stay where they are while the path is closed.

Top module: `xcvr16`

## Requirements
- R1: With a path's enable and latch enable both low and its clear high, the destination value equals the source value in the same cycle.
- R2: When the latch enable of an open path goes high, the destination shows the source value sampled at the last clock before the change, and later source changes are ignored.
- R3: When the path enable goes high while the latch enable is low, the value is captured in the same way. It is shown again once the enable returns low with the latch enable high.
- R4: While a path is closed (enable or latch enable high), its stored value and destination value stay the same whatever the source does.
- R5: All eight output-enable bits of a path's destination byte are 1 exactly when that path's enable and output enable are both low, and 0 otherwise.
- R6: A path keeps capturing while its output enable is high. Lowering the output enable later shows the captured value.
- R7: A low master clear for a direction forces that direction's destination values to zero in every half at once. This overrides transparency. After release the storage stays zero until the path opens again.
- R8: The A-to-B clear does not change B-to-A storage or outputs, and the B-to-A clear does not change A-to-B storage or outputs.
- R9: A capture or a change in one half leaves the other half's stored value and outputs unchanged.
- R10: Bit k of half h carries a_in[8h+k] to b_out[8h+k] and b_in[8h+k] to a_out[8h+k]. Control bit h of each control vector belongs to half h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the storage and state registers |
| mr_ab_n | input | 1 | Active-low clear of all A-to-B storage |
| mr_ba_n | input | 1 | Active-low clear of all B-to-A storage |
| en_ab_n | input | HALVES | Active-low A-to-B path enable, one bit per half |
| le_ab_n | input | HALVES | Active-low A-to-B latch enable, one bit per half |
| oe_ab_n | input | HALVES | Active-low A-to-B output enable, one bit per half |
| en_ba_n | input | HALVES | Active-low B-to-A path enable, one bit per half |
| le_ba_n | input | HALVES | Active-low B-to-A latch enable, one bit per half |
| oe_ba_n | input | HALVES | Active-low B-to-A output enable, one bit per half |
| a_in | input | HALF_W*HALVES | Value seen on the A pads |
| a_out | output | HALF_W*HALVES | Value for the A pads (from B-to-A paths) |
| a_oe | output | HALF_W*HALVES | Per-bit drive enable for the A pads |
| b_in | input | HALF_W*HALVES | Value seen on the B pads |
| b_out | output | HALF_W*HALVES | Value for the B pads (from A-to-B paths) |
| b_oe | output | HALF_W*HALVES | Per-bit drive enable for the B pads |

## Verification
The bench builds the block with its default parameters, HALF_W = 8 and HALVES = 2. This is the full 16-bit, four-path configuration, and it is small enough that a long pseudo-random sweep covers every combination of enable, latch enable and output enable on each path, many times over, with clears mixed in. The expected values come from a per-path behavioural model in the bench. Directed sequences before the sweep pin down the edge captures, the capture by enable, the per-direction clears and the isolation between halves with fixed byte values.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
    typedef enum logic [1:0] {
        PS_CLEAR = 2'd0,
        PS_OPEN  = 2'd1,
        PS_HOLD  = 2'd2
    } path_state_t;
endpackage

// File: rtl/xcvr_path.sv
`timescale 1ns/1ps
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         mr_n,
    input  logic         en_n,
    input  logic         le_n,
    input  logic         oe_n,
    input  logic [W-1:0] src,
    output logic [W-1:0] dst,
    output logic         dst_oe
);
    path_state_t state, state_nxt;
    logic [W-1:0] store;
    logic         open_now;

    assign open_now = !en_n && !le_n;

    // next-state selection
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_CLEAR: state_nxt = open_now ? PS_OPEN : PS_CLEAR;
            PS_OPEN:  state_nxt = open_now ? PS_OPEN : PS_HOLD;
            PS_HOLD:  state_nxt = open_now ? PS_OPEN : PS_HOLD;
            default:  state_nxt = PS_CLEAR;
        endcase
    end

    // state register, cleared asynchronously by the master clear
    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n) state <= PS_CLEAR;
        else       state <= state_nxt;
    end

    // storage samples the source every clock the path is open
    always_ff @(posedge clk or negedge mr_n) begin
        if (!mr_n)         store <= '0;
        else if (open_now) store <= src;
    end

    // outputs
    always_comb begin
        dst_oe = !en_n && !oe_n;
        if (!mr_n)         dst = '0;
        else if (open_now) dst = src;
        else begin
            unique case (state)
                PS_CLEAR: dst = '0;
                default:  dst = store;
            endcase
        end
    end

    assert_capture_R2: assert property (@(posedge clk) disable iff (!mr_n)
        ($past(open_now) && !open_now && $past(mr_n)) |-> (dst == $past(src)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!mr_n)
        (!open_now && $past(mr_n)) |=> (open_now || dst == $past(dst)));

    assert_clear_R7: assert property (@(posedge clk)
        !mr_n |-> (dst == '0));

    assert_oe_off_R5: assert property (@(posedge clk) disable iff (!mr_n)
        (en_n || oe_n) |-> !dst_oe);
endmodule

// File: rtl/xcvr_half.sv
`timescale 1ns/1ps
module xcvr_half #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         mr_ab_n,
    input  logic         mr_ba_n,
    input  logic         en_ab_n,
    input  logic         le_ab_n,
    input  logic         oe_ab_n,
    input  logic         en_ba_n,
    input  logic         le_ba_n,
    input  logic         oe_ba_n,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe
);
    logic ab_drive, ba_drive;

    xcvr_path #(.W(W)) u_ab (
        .clk(clk), .mr_n(mr_ab_n), .en_n(en_ab_n), .le_n(le_ab_n),
        .oe_n(oe_ab_n), .src(a_in), .dst(b_out), .dst_oe(ab_drive)
    );

    xcvr_path #(.W(W)) u_ba (
        .clk(clk), .mr_n(mr_ba_n), .en_n(en_ba_n), .le_n(le_ba_n),
        .oe_n(oe_ba_n), .src(b_in), .dst(a_out), .dst_oe(ba_drive)
    );

    assign b_oe = {W{ab_drive}};
    assign a_oe = {W{ba_drive}};

    assert_ab_clear_isolated_R8: assert property (@(posedge clk) disable iff (!mr_ba_n)
        (!mr_ab_n && $past(mr_ba_n) && en_ba_n && $past(en_ba_n)) |=> (en_ba_n -> $stable(a_out)));
endmodule

// File: rtl/xcvr16.sv
`timescale 1ns/1ps
module xcvr16 #(
    parameter int HALF_W = 8,
    parameter int HALVES = 2
) (
    input  logic                       clk,
    input  logic                       mr_ab_n,
    input  logic                       mr_ba_n,
    input  logic [HALVES-1:0]          en_ab_n,
    input  logic [HALVES-1:0]          le_ab_n,
    input  logic [HALVES-1:0]          oe_ab_n,
    input  logic [HALVES-1:0]          en_ba_n,
    input  logic [HALVES-1:0]          le_ba_n,
    input  logic [HALVES-1:0]          oe_ba_n,
    input  logic [HALF_W*HALVES-1:0]   a_in,
    output logic [HALF_W*HALVES-1:0]   a_out,
    output logic [HALF_W*HALVES-1:0]   a_oe,
    input  logic [HALF_W*HALVES-1:0]   b_in,
    output logic [HALF_W*HALVES-1:0]   b_out,
    output logic [HALF_W*HALVES-1:0]   b_oe
);
    localparam int BUS_W = HALF_W * HALVES;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        xcvr_half #(.W(HALF_W)) u_half (
            .clk     (clk),
            .mr_ab_n (mr_ab_n),
            .mr_ba_n (mr_ba_n),
            .en_ab_n (en_ab_n[h]),
            .le_ab_n (le_ab_n[h]),
            .oe_ab_n (oe_ab_n[h]),
            .en_ba_n (en_ba_n[h]),
            .le_ba_n (le_ba_n[h]),
            .oe_ba_n (oe_ba_n[h]),
            .a_in    (a_in [h*HALF_W +: HALF_W]),
            .b_in    (b_in [h*HALF_W +: HALF_W]),
            .a_out   (a_out[h*HALF_W +: HALF_W]),
            .a_oe    (a_oe [h*HALF_W +: HALF_W]),
            .b_out   (b_out[h*HALF_W +: HALF_W]),
            .b_oe    (b_oe [h*HALF_W +: HALF_W])
        );
    end

    assert_bus_clear_R7: assert property (@(posedge clk)
        !mr_ab_n |-> (b_out == {BUS_W{1'b0}}));
endmodule

// File: tb/xcvr16_test.sv
`timescale 1ns/1ps
module xcvr16_test;
    logic        clk = 1'b0;
    logic        mr_ab_n, mr_ba_n;
    logic [3:0]  en_v, le_v, oe_v;   // paths 0,1 = AB half0/1; 2,3 = BA half0/1
    logic [15:0] a_in, b_in;
    logic [15:0] a_out, a_oe, b_out, b_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] m_store [4];

    always #2.5 clk = ~clk;

    xcvr16 uut (
        .clk(clk), .mr_ab_n(mr_ab_n), .mr_ba_n(mr_ba_n),
        .en_ab_n(en_v[1:0]), .le_ab_n(le_v[1:0]), .oe_ab_n(oe_v[1:0]),
        .en_ba_n(en_v[3:2]), .le_ba_n(le_v[3:2]), .oe_ba_n(oe_v[3:2]),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    function automatic logic [7:0] src_of(int p);
        return (p < 2) ? a_in[p*8 +: 8] : b_in[(p-2)*8 +: 8];
    endfunction
    function automatic logic [7:0] dst_of(int p);
        return (p < 2) ? b_out[p*8 +: 8] : a_out[(p-2)*8 +: 8];
    endfunction
    function automatic logic [7:0] oe_of(int p);
        return (p < 2) ? b_oe[p*8 +: 8] : a_oe[(p-2)*8 +: 8];
    endfunction
    function automatic logic mr_of(int p);
        return (p < 2) ? mr_ab_n : mr_ba_n;
    endfunction

    // behavioural model of the storage, from the requirements
    always @(posedge clk) begin
        for (int p = 0; p < 4; p++) begin
            if (!mr_of(p))                 m_store[p] = 8'h00;
            else if (!en_v[p] && !le_v[p]) m_store[p] = src_of(p);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic sweep_check();
        for (int p = 0; p < 4; p++) begin
            logic [7:0] e;
            string tg;
            if (!mr_of(p))                 begin e = 8'h00;      tg = "R7 clear";  end
            else if (!en_v[p] && !le_v[p]) begin e = src_of(p);  tg = "R1 open";   end
            else                           begin e = m_store[p]; tg = "R4 hold/R2 capture"; end
            chk(tg, {24'd0, dst_of(p)}, {24'd0, e});
            chk("R5 oe", {24'd0, oe_of(p)}, {24'd0, {8{!en_v[p] && !oe_v[p]}}});
        end
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        mr_ab_n = 1'b0; mr_ba_n = 1'b0;
        en_v = 4'hF; le_v = 4'hF; oe_v = 4'hF;
        a_in = 16'h0; b_in = 16'h0;
        repeat (3) @(negedge clk);
        #1;
        chk("R7 reset b_out", {16'd0, b_out}, 32'h0);
        chk("R7 reset a_out", {16'd0, a_out}, 32'h0);
        chk("R5 reset b_oe", {16'd0, b_oe}, 32'h0);

        // R1 / R10: both AB halves open
        @(negedge clk);
        mr_ab_n = 1'b1; mr_ba_n = 1'b1;
        en_v[1:0] = 2'b00; le_v[1:0] = 2'b00; oe_v[1:0] = 2'b00;
        a_in = 16'h775A;
        #1;
        chk("R1 R10 transparent", {16'd0, b_out}, 32'h775A);
        chk("R5 oe on", {16'd0, b_oe}, 32'hFFFF);

        // half1 captures 77
        @(negedge clk);
        le_v[1] = 1'b1; a_in = 16'h115A;
        #1;
        chk("R2 half1 capture", {16'd0, b_out}, 32'h775A);

        // half0 captures 5A; half1 stays
        @(negedge clk);
        le_v[0] = 1'b1; a_in = 16'h22C3;
        #1;
        chk("R2 half0 capture", {24'd0, b_out[7:0]}, 32'h5A);
        chk("R9 half1 unchanged", {24'd0, b_out[15:8]}, 32'h77);

        @(negedge clk);
        a_in = 16'h330F;
        #1;
        chk("R4 hold", {16'd0, b_out}, 32'h775A);

        // R3: capture through the enable
        @(negedge clk);
        le_v[1] = 1'b0; a_in = 16'h3C0F;
        #1;
        chk("R1 half1 reopen", {24'd0, b_out[15:8]}, 32'h3C);
        chk("R9 half0 unchanged", {24'd0, b_out[7:0]}, 32'h5A);
        @(negedge clk);
        en_v[1] = 1'b1; a_in = 16'h990F;
        #1;
        chk("R5 en high oe off", {24'd0, b_oe[15:8]}, 32'h0);
        @(negedge clk);
        en_v[1] = 1'b0; le_v[1] = 1'b1;
        #1;
        chk("R3 enable capture", {24'd0, b_out[15:8]}, 32'h3C);
        chk("R5 oe back on", {24'd0, b_oe[15:8]}, 32'hFF);

        // R6: BA half0 captures with outputs off
        @(negedge clk);
        en_v[2] = 1'b0; le_v[2] = 1'b0; oe_v[2] = 1'b1; b_in = 16'h00A5;
        #1;
        chk("R6 oe off while open", {24'd0, a_oe[7:0]}, 32'h0);
        @(negedge clk);
        le_v[2] = 1'b1; b_in = 16'h0000;
        #1;
        chk("R6 oe still off", {24'd0, a_oe[7:0]}, 32'h0);
        @(negedge clk);
        oe_v[2] = 1'b0;
        #1;
        chk("R6 captured shown", {24'd0, a_out[7:0]}, 32'hA5);
        chk("R5 BA oe on", {24'd0, a_oe[7:0]}, 32'hFF);

        // R7 / R8: AB clear with half0 open
        @(negedge clk);
        le_v[0] = 1'b0; mr_ab_n = 1'b0;
        #1;
        chk("R7 clear over transparency", {16'd0, b_out}, 32'h0);
        chk("R8 BA kept under AB clear", {24'd0, a_out[7:0]}, 32'hA5);
        @(negedge clk);
        mr_ab_n = 1'b1;
        #1;
        chk("R1 after clear", {24'd0, b_out[7:0]}, 32'h0F);
        chk("R7 storage stays zero", {24'd0, b_out[15:8]}, 32'h00);
        @(negedge clk);
        mr_ba_n = 1'b0;
        #1;
        chk("R7 BA clear", {16'd0, a_out}, 32'h0);
        chk("R8 AB kept under BA clear", {24'd0, b_out[7:0]}, 32'h0F);
        @(negedge clk);
        mr_ba_n = 1'b1;
        #1;
        chk("R7 BA stays zero", {24'd0, a_out[7:0]}, 32'h00);

        // near-exhaustive sweep over controls, data and clears
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            en_v = lfsr[3:0] & lfsr[7:4];
            le_v = lfsr[11:8];
            oe_v = lfsr[15:12] & lfsr[19:16];
            mr_ab_n = (lfsr[23:20] != 4'h0);
            mr_ba_n = (lfsr[27:24] != 4'h0);
            a_in = lfsr[31:16] ^ {lfsr[15:0]};
            b_in = {lfsr[7:0], lfsr[31:24]};
            #1;
            sweep_check();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule